// File: doc/BRIEF.md
# Request Frame Checker and Command Dispatcher

This block sits between the receive symbol decoder of a contactless tag and its command engine. It takes the decoded bytes of one reader request, framed by a start marker and an end marker. The first byte is the request flags and the second is the command code. The last two bytes are a CRC16 check word, and every byte in between is payload. The block checks the CRC and maps the command code to a compact command identifier. One cycle after the end marker it reports exactly one verdict: accept, discard or reject as unsupported.

Payload bytes are streamed out with their index while the frame is still arriving. The block holds back the two most recent bytes, so the check word never leaks out as payload. Four vendor codes carry a signed check word: the plain CRC XORed with a 16-bit key picked by a selector input. A timing error reported by the decoder during the frame always leads to a discard.

Top module: `rfc_request_checker`

## Requirements
- R1: While reset is asserted and after it is released, `outcome_valid` and `pl_valid` are low, `outcome` is 0 and `cmd_id` is 15 until the first verdict.
- R2: A frame opens on `sof`. Bytes and `eof` seen while no frame is open are ignored: they produce no payload and no verdict. A new `sof` inside an open frame discards what was gathered and restarts.
- R3: The check word is a CRC16 over the flags byte through the last payload byte. It uses the reflected polynomial 0x8408, starts from 0xFFFF and is sent ones'-complemented, low byte first. A supported non-secure code with a matching check word is accepted.
- R4: Supported codes map to `cmd_id` values: 0x01→0, 0x02→1, 0x21→2, 0x22→3, 0x23→4, 0x25→5, 0x26→6, 0x27→7. Any other code outside 0xF0–0xF3 reports id 15.
- R5: Codes 0xF0–0xF3 map to ids 8–11. They are accepted only when the check word equals the plain CRC XOR the low 16 bits of the key chosen by `key_sel`. A plain check word or another key's check word gives a discard.
- R6: An unsupported code whose plain check word is correct is rejected (`outcome`=3, `cmd_id`=15). With a wrong check word it is discarded.
- R7: A `timing_err` pulse inside an open frame forces a discard of that frame. Pulses outside a frame have no effect.
- R8: A frame of fewer than four bytes (flags, code and two check bytes) is discarded.
- R9: Payload byte k of a frame appears on `pl_data` with `pl_index`=k and `pl_valid` high, in arrival order. The two check-word bytes never appear. On a verdict other than discard, `req_flags` shows the frame's flags byte.
- R10: A frame whose payload is longer than `MAX_PAYLOAD` bytes is discarded. Only its first `MAX_PAYLOAD` payload bytes are emitted.
- R11: `outcome_valid` is high for exactly one cycle, the cycle after `eof` of an open frame. `outcome` is then 1 for accept, 2 for discard and 3 for reject.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sof | input | 1 | Start-of-frame pulse |
| eof | input | 1 | End-of-frame pulse |
| byte_valid | input | 1 | Decoded byte present |
| byte_data | input | 8 | Decoded byte |
| timing_err | input | 1 | Decoder timing violation pulse |
| key_sel | input | KSEL_W (2) | Key choice for signed check words, sampled at `eof` |
| key_table | input | NUM_KEYS*16 (64) | Low 16 bits of each key, key 0 in the lowest bits |
| pl_valid | output | 1 | Payload byte strobe |
| pl_data | output | 8 | Payload byte |
| pl_index | output | PIDX_W (5) | Position of the payload byte |
| req_flags | output | 8 | Flags byte of the judged frame |
| cmd_id | output | 4 | Command identifier of the judged frame |
| outcome_valid | output | 1 | Verdict strobe |
| outcome | output | 2 | Verdict code |

## Verification
The assertions rely on three input rules. `sof` never shares a cycle with `byte_valid` or `eof`. `eof` never shares a cycle with `byte_valid`. `key_sel` names an existing key whenever `eof` is high. The bench drives each marker and each byte in its own cycle on the falling edge, and it only sets `key_sel` to an index below `NUM_KEYS`. Timing-error pulses are placed in idle cycles between bytes, so every input rule holds for the whole run.

// File: rtl/rfc_pkg.sv
package rfc_pkg;

   localparam logic [15:0] CRC_INIT = 16'hFFFF;
   localparam logic [15:0] CRC_POLY = 16'h8408;

   typedef enum logic [3:0] {
      CMD_INVENTORY  = 4'd0,
      CMD_QUIET      = 4'd1,
      CMD_WRITE_BLK  = 4'd2,
      CMD_LOCK_BLK   = 4'd3,
      CMD_READ_MULTI = 4'd4,
      CMD_SELECT     = 4'd5,
      CMD_TO_READY   = 4'd6,
      CMD_AFI_EAS    = 4'd7,
      CMD_SEC_AUTH_A = 4'd8,
      CMD_SEC_AUTH_B = 4'd9,
      CMD_SEC_WRITE  = 4'd10,
      CMD_SEC_READ   = 4'd11,
      CMD_NONE       = 4'd15
   } cmd_id_e;

   typedef enum logic [1:0] {
      VERDICT_NONE    = 2'd0,
      VERDICT_ACCEPT  = 2'd1,
      VERDICT_DISCARD = 2'd2,
      VERDICT_REJECT  = 2'd3
   } verdict_e;

   // one byte of the reflected CRC16, least significant bit first
   function automatic logic [15:0] crc16_byte(input logic [15:0] c_in,
                                              input logic [7:0]  d);
      logic [15:0] c;
      c = c_in;
      for (int i = 0; i < 8; i++) begin
         if (c[0] ^ d[i]) c = (c >> 1) ^ CRC_POLY;
         else             c = c >> 1;
      end
      return c;
   endfunction

endpackage

// File: rtl/rfc_crc16.sv
module rfc_crc16
   import rfc_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        clear,
   input  logic        en,
   input  logic [7:0]  din,
   output logic [15:0] crc_q
);

   always_ff @(posedge clk) begin
      if (!rst_n)     crc_q <= CRC_INIT;
      else if (clear) crc_q <= CRC_INIT;
      else if (en)    crc_q <= crc16_byte(crc_q, din);
   end

   // a restart always leaves the register at the seed
   p_crc_seed_r3: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (crc_q == CRC_INIT));

endmodule

// File: rtl/rfc_holdback.sv
module rfc_holdback #(
   parameter int CNT_W   = 6,
   parameter int CNT_SAT = 34
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             push,
   input  logic [7:0]       din,
   output logic             exit_valid,
   output logic [7:0]       exit_byte,
   output logic [CNT_W-1:0] exit_cnt,
   output logic [7:0]       hold_new,
   output logic [7:0]       hold_old,
   output logic             full
);

   localparam logic [CNT_W-1:0] SAT_V = CNT_W'(CNT_SAT);

   logic [1:0] fill;

   assign full       = (fill == 2'd2);
   assign exit_valid = push && full;
   assign exit_byte  = hold_old;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fill     <= 2'd0;
         exit_cnt <= '0;
         hold_new <= 8'h00;
         hold_old <= 8'h00;
      end else if (clear) begin
         fill     <= 2'd0;
         exit_cnt <= '0;
      end else if (push) begin
         hold_old <= hold_new;
         hold_new <= din;
         if (!full) fill <= fill + 2'd1;
         if (exit_valid && exit_cnt != SAT_V) exit_cnt <= exit_cnt + 1'b1;
      end
   end

   p_fill_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= 2'd2);

   p_exit_count_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
      exit_cnt <= SAT_V);

endmodule

// File: rtl/rfc_cmd_lut.sv
module rfc_cmd_lut
   import rfc_pkg::*;
(
   input  logic [7:0] code,
   output cmd_id_e    id,
   output logic       supported,
   output logic       secure
);

   always_comb begin
      supported = 1'b1;
      secure    = 1'b0;
      unique case (code)
         8'h01: id = CMD_INVENTORY;
         8'h02: id = CMD_QUIET;
         8'h21: id = CMD_WRITE_BLK;
         8'h22: id = CMD_LOCK_BLK;
         8'h23: id = CMD_READ_MULTI;
         8'h25: id = CMD_SELECT;
         8'h26: id = CMD_TO_READY;
         8'h27: id = CMD_AFI_EAS;
         8'hF0: begin id = CMD_SEC_AUTH_A; secure = 1'b1; end
         8'hF1: begin id = CMD_SEC_AUTH_B; secure = 1'b1; end
         8'hF2: begin id = CMD_SEC_WRITE;  secure = 1'b1; end
         8'hF3: begin id = CMD_SEC_READ;   secure = 1'b1; end
         default: begin id = CMD_NONE; supported = 1'b0; end
      endcase
   end

endmodule

// File: rtl/rfc_request_checker.sv
module rfc_request_checker
   import rfc_pkg::*;
#(
   parameter int MAX_PAYLOAD = 32,
   parameter int NUM_KEYS    = 4,
   localparam int KSEL_W     = (NUM_KEYS > 1) ? $clog2(NUM_KEYS) : 1,
   localparam int PIDX_W     = (MAX_PAYLOAD > 1) ? $clog2(MAX_PAYLOAD) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   sof,
   input  logic                   eof,
   input  logic                   byte_valid,
   input  logic [7:0]             byte_data,
   input  logic                   timing_err,
   input  logic [KSEL_W-1:0]      key_sel,
   input  logic [NUM_KEYS*16-1:0] key_table,
   output logic                   pl_valid,
   output logic [7:0]             pl_data,
   output logic [PIDX_W-1:0]      pl_index,
   output logic [7:0]             req_flags,
   output logic [3:0]             cmd_id,
   output logic                   outcome_valid,
   output logic [1:0]             outcome
);

   localparam int CNT_SAT  = MAX_PAYLOAD + 2;
   localparam int CNT_W    = $clog2(CNT_SAT + 1);
   localparam int KEY_SLOTS = 1 << KSEL_W;
   localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(CNT_SAT);
   localparam logic [CNT_W-1:0] CNT_TWO   = CNT_W'(2);

   if (MAX_PAYLOAD < 1 || MAX_PAYLOAD > 250) begin : g_bad_payload
      $error("MAX_PAYLOAD must lie in 1..250");
   end
   if (NUM_KEYS < 1 || NUM_KEYS > 16) begin : g_bad_keys
      $error("NUM_KEYS must lie in 1..16");
   end

   // ---------------- key slots, padded to a power of two ----------------
   logic [15:0] key_slot [KEY_SLOTS];
   for (genvar g = 0; g < KEY_SLOTS; g++) begin : g_key
      if (g < NUM_KEYS) begin : g_real
         assign key_slot[g] = key_table[g*16 +: 16];
      end else begin : g_pad
         assign key_slot[g] = 16'h0000;
      end
   end

   // ---------------- frame state ----------------
   logic in_frame, terr_q, ovf_q;
   logic [7:0] flags_q, code_q;
   logic push;

   assign push = byte_valid && in_frame;

   // ---------------- holdback of the two newest bytes ----------------
   logic             hb_exit, hb_full;
   logic [7:0]       hb_exit_byte, hb_new, hb_old;
   logic [CNT_W-1:0] hb_cnt;

   rfc_holdback #(.CNT_W(CNT_W), .CNT_SAT(CNT_SAT)) u_hold (
      .clk(clk), .rst_n(rst_n), .clear(sof), .push(push), .din(byte_data),
      .exit_valid(hb_exit), .exit_byte(hb_exit_byte), .exit_cnt(hb_cnt),
      .hold_new(hb_new), .hold_old(hb_old), .full(hb_full)
   );

   // ---------------- CRC over bytes leaving the holdback ----------------
   logic [15:0] crc_q;

   rfc_crc16 u_crc (
      .clk(clk), .rst_n(rst_n), .clear(sof), .en(hb_exit),
      .din(hb_exit_byte), .crc_q(crc_q)
   );

   // ---------------- command classification ----------------
   cmd_id_e lut_id;
   logic    lut_sup, lut_sec;

   rfc_cmd_lut u_lut (.code(code_q), .id(lut_id), .supported(lut_sup), .secure(lut_sec));

   // ---------------- frame bookkeeping and payload stream ----------------
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         in_frame <= 1'b0;
         terr_q   <= 1'b0;
         ovf_q    <= 1'b0;
         flags_q  <= 8'h00;
         code_q   <= 8'h00;
         pl_valid <= 1'b0;
         pl_data  <= 8'h00;
         pl_index <= '0;
      end else begin
         pl_valid <= 1'b0;
         if (sof) begin
            in_frame <= 1'b1;
            terr_q   <= 1'b0;
            ovf_q    <= 1'b0;
         end else begin
            if (eof) in_frame <= 1'b0;
            if (in_frame && timing_err) terr_q <= 1'b1;
            if (hb_exit) begin
               if (hb_cnt == '0)              flags_q <= hb_exit_byte;
               else if (hb_cnt == CNT_W'(1))  code_q  <= hb_exit_byte;
               else if (hb_cnt < CNT_LIMIT) begin
                  pl_valid <= 1'b1;
                  pl_data  <= hb_exit_byte;
                  pl_index <= PIDX_W'(hb_cnt - CNT_TWO);
               end else begin
                  ovf_q <= 1'b1;
               end
            end
         end
      end
   end

   // ---------------- verdict ----------------
   logic [15:0] crc_calc, crc_rx, crc_signed;
   logic        too_short, plain_ok, signed_ok;
   verdict_e    verdict;

   assign crc_calc   = ~crc_q;
   assign crc_rx     = {hb_new, hb_old};   // low byte arrived first
   assign crc_signed = crc_calc ^ key_slot[key_sel];
   assign plain_ok   = (crc_rx == crc_calc);
   assign signed_ok  = (crc_rx == crc_signed);
   assign too_short  = !(hb_full && hb_cnt >= CNT_TWO);

   always_comb begin
      if (too_short || terr_q || ovf_q)     verdict = VERDICT_DISCARD;
      else if (!lut_sup)                    verdict = plain_ok  ? VERDICT_REJECT : VERDICT_DISCARD;
      else if (lut_sec)                     verdict = signed_ok ? VERDICT_ACCEPT : VERDICT_DISCARD;
      else                                  verdict = plain_ok  ? VERDICT_ACCEPT : VERDICT_DISCARD;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         outcome_valid <= 1'b0;
         outcome       <= VERDICT_NONE;
         cmd_id        <= CMD_NONE;
         req_flags     <= 8'h00;
      end else begin
         outcome_valid <= 1'b0;
         if (eof && in_frame && !sof) begin
            outcome_valid <= 1'b1;
            outcome       <= verdict;
            req_flags     <= flags_q;
            cmd_id        <= (verdict == VERDICT_DISCARD || !lut_sup) ? CMD_NONE : lut_id;
         end
      end
   end

   // ---------------- input rules ----------------
   p_sof_alone_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sof |-> (!byte_valid && !eof));

   p_eof_no_byte_r11: assert property (@(posedge clk) disable iff (!rst_n)
      eof |-> !byte_valid);

   p_keysel_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      eof |-> (32'(key_sel) < NUM_KEYS));

   // ---------------- behaviour ----------------
   p_verdict_after_eof_r11: assert property (@(posedge clk) disable iff (!rst_n)
      outcome_valid |-> $past(eof));

   p_verdict_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
      outcome_valid |=> !outcome_valid);

   p_verdict_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
      outcome_valid |-> (outcome != VERDICT_NONE));

   p_reject_id_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (outcome_valid && outcome == VERDICT_REJECT) |-> (cmd_id == CMD_NONE));

   p_payload_from_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
      pl_valid |-> $past(byte_valid));

endmodule

// File: tb/tb_rfc_request_checker.sv
module tb_rfc_request_checker;
   import rfc_pkg::*;

   localparam int MAXP  = 32;
   localparam int NKEYS = 4;

   typedef struct packed {
      logic [7:0] code;
      logic [5:0] plen;
      logic [1:0] mode;     // 0 plain, 1 corrupt, 2 signed, 3 signed with wrong key
      logic [1:0] ksel;
      logic       terr;
      logic [1:0] exp_out;
      logic [3:0] exp_id;
   } vec_t;

   localparam int NV = 18;
   localparam vec_t VECS [0:NV-1] = '{
      '{8'h01, 6'd1,  2'd0, 2'd0, 1'b0, 2'd1, 4'd0 },   // R3 R4 inventory
      '{8'h02, 6'd8,  2'd0, 2'd0, 1'b0, 2'd1, 4'd1 },   // R4 quiet
      '{8'h21, 6'd5,  2'd0, 2'd0, 1'b0, 2'd1, 4'd2 },   // R4 write block
      '{8'h22, 6'd1,  2'd0, 2'd0, 1'b0, 2'd1, 4'd3 },
      '{8'h23, 6'd2,  2'd0, 2'd0, 1'b0, 2'd1, 4'd4 },
      '{8'h25, 6'd8,  2'd0, 2'd0, 1'b0, 2'd1, 4'd5 },
      '{8'h26, 6'd0,  2'd0, 2'd0, 1'b0, 2'd1, 4'd6 },
      '{8'h27, 6'd2,  2'd0, 2'd0, 1'b0, 2'd1, 4'd7 },
      '{8'h21, 6'd5,  2'd1, 2'd0, 1'b0, 2'd2, 4'd15},   // R3 bad CRC
      '{8'hF0, 6'd3,  2'd2, 2'd0, 1'b0, 2'd1, 4'd8 },   // R5 signed
      '{8'hF1, 6'd3,  2'd2, 2'd3, 1'b0, 2'd1, 4'd9 },
      '{8'hF2, 6'd5,  2'd2, 2'd2, 1'b0, 2'd1, 4'd10},
      '{8'hF3, 6'd4,  2'd2, 2'd1, 1'b0, 2'd1, 4'd11},
      '{8'hF0, 6'd2,  2'd0, 2'd0, 1'b0, 2'd2, 4'd15},   // R5 plain on secure
      '{8'hF3, 6'd2,  2'd3, 2'd1, 1'b0, 2'd2, 4'd15},   // R5 wrong key
      '{8'h99, 6'd2,  2'd0, 2'd0, 1'b0, 2'd3, 4'd15},   // R6 reject
      '{8'hF4, 6'd1,  2'd1, 2'd0, 1'b0, 2'd2, 4'd15},   // R6 bad CRC
      '{8'h27, 6'd2,  2'd0, 2'd0, 1'b1, 2'd2, 4'd15}    // R7 timing error
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sof = 1'b0, eof = 1'b0, byte_valid = 1'b0, timing_err = 1'b0;
   logic [7:0] byte_data = 8'h00;
   logic [1:0] key_sel = 2'd0;
   logic [NKEYS*16-1:0] key_table;
   logic pl_valid, outcome_valid;
   logic [7:0] pl_data, req_flags;
   logic [4:0] pl_index;
   logic [3:0] cmd_id;
   logic [1:0] outcome;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   logic [7:0] cap [0:63];
   int cap_n = 0;
   bit idx_bad = 1'b0;

   always #2.5 clk = ~clk;

   function automatic logic [15:0] key_of(input int i);
      return 16'h3C5A + 16'(i) * 16'h1111;
   endfunction

   always_comb begin
      for (int i = 0; i < NKEYS; i++) key_table[i*16 +: 16] = key_of(i);
   end

   rfc_request_checker #(.MAX_PAYLOAD(MAXP), .NUM_KEYS(NKEYS)) dut (
      .clk(clk), .rst_n(rst_n), .sof(sof), .eof(eof), .byte_valid(byte_valid),
      .byte_data(byte_data), .timing_err(timing_err), .key_sel(key_sel),
      .key_table(key_table), .pl_valid(pl_valid), .pl_data(pl_data),
      .pl_index(pl_index), .req_flags(req_flags), .cmd_id(cmd_id),
      .outcome_valid(outcome_valid), .outcome(outcome)
   );

   always @(negedge clk) begin
      if (pl_valid) begin
         if (cap_n < 64) cap[cap_n] = pl_data;
         if (int'(pl_index) != cap_n) idx_bad = 1'b1;
         cap_n++;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] crc_step(input logic [15:0] c_in, input logic [7:0] d);
      logic [15:0] c = c_in;
      for (int i = 0; i < 8; i++) c = (c[0] ^ d[i]) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
      return c;
   endfunction

   function automatic logic [7:0] pbyte(input logic [7:0] code, input int j);
      return code + 8'(j * 37 + 5);
   endfunction

   task automatic put_byte(input logic [7:0] b);
      byte_valid = 1'b1; byte_data = b;
      @(negedge clk);
      byte_valid = 1'b0;
   endtask

   task automatic run_vec(input vec_t v);
      logic [15:0] c, w;
      int n_exp;
      cap_n = 0; idx_bad = 1'b0;
      key_sel = v.ksel;
      sof = 1'b1; @(negedge clk); sof = 1'b0;
      c = 16'hFFFF;
      put_byte(8'h02); c = crc_step(c, 8'h02);
      put_byte(v.code); c = crc_step(c, v.code);
      if (v.terr) begin timing_err = 1'b1; @(negedge clk); timing_err = 1'b0; end
      for (int j = 0; j < int'(v.plen); j++) begin
         put_byte(pbyte(v.code, j)); c = crc_step(c, pbyte(v.code, j));
      end
      w = ~c;
      case (v.mode)
         2'd1: w = w ^ 16'h0001;
         2'd2: w = w ^ key_of(int'(v.ksel));
         2'd3: w = w ^ key_of(int'(v.ksel ^ 2'd1));
         default: ;
      endcase
      put_byte(w[7:0]); put_byte(w[15:8]);
      eof = 1'b1; @(negedge clk); eof = 1'b0;
      check(outcome_valid == 1'b1, "R11 strobe", outcome_valid, 1);
      check(outcome == v.exp_out, "R3/R5/R6/R7 verdict", outcome, v.exp_out);
      if (v.exp_out != 2'd2) begin
         check(cmd_id == v.exp_id, "R4 id", cmd_id, v.exp_id);
         check(req_flags == 8'h02, "R9 flags", req_flags, 8'h02);
      end
      n_exp = (int'(v.plen) > MAXP) ? MAXP : int'(v.plen);
      check(cap_n == n_exp && !idx_bad, "R9 payload count", cap_n, n_exp);
      for (int j = 0; j < n_exp; j++)
         check(cap[j] == pbyte(v.code, j), "R9 payload byte", cap[j], pbyte(v.code, j));
      @(negedge clk);
      check(outcome_valid == 1'b0, "R11 single strobe", outcome_valid, 0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         errors++; checks++;
         $display("FAIL R11 watchdog actual=hung expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(outcome_valid == 0 && pl_valid == 0, "R1 strobes in reset", {outcome_valid, pl_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(outcome == 2'd0, "R1 outcome", outcome, 0);
      check(cmd_id == 4'd15, "R1 cmd_id", cmd_id, 15);
      check(outcome_valid == 0, "R1 no strobe", outcome_valid, 0);

      for (int i = 0; i < NV; i++) run_vec(VECS[i]);

      // R10: payload one byte longer than the limit
      run_vec('{8'h23, 6'(MAXP + 1), 2'd0, 2'd0, 1'b0, 2'd2, 4'd15});

      // R8: three-byte frame
      sof = 1'b1; @(negedge clk); sof = 1'b0;
      put_byte(8'h02); put_byte(8'h01); put_byte(8'hAA);
      eof = 1'b1; @(negedge clk); eof = 1'b0;
      check(outcome_valid == 1 && outcome == 2'd2, "R8 short frame", outcome, 2);
      @(negedge clk);

      // R2: bytes and eof with no open frame
      cap_n = 0;
      put_byte(8'h02); put_byte(8'h01); put_byte(8'h11); put_byte(8'h22); put_byte(8'h33);
      eof = 1'b1; @(negedge clk); eof = 1'b0;
      check(outcome_valid == 0, "R2 stray eof", outcome_valid, 0);
      @(negedge clk);
      check(cap_n == 0, "R2 stray bytes", cap_n, 0);

      // R2: restart by a second sof, then a clean frame
      sof = 1'b1; @(negedge clk); sof = 1'b0;
      put_byte(8'h02); put_byte(8'hF2); put_byte(8'h44); put_byte(8'h55);
      run_vec(VECS[0]);

      // R7: timing error outside any frame has no effect
      timing_err = 1'b1; @(negedge clk); timing_err = 1'b0;
      run_vec(VECS[7]);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule